// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor's request port and the request queue of a cache controller. It keeps a record of every request it has admitted until the matching completion comes back. Requests that copy data out of a line (plain loads and instruction fetches) are held in a read-class table. Requests that modify or reserve a line (stores, both halves of an atomic read-modify-write, and both halves of a locked pair) are held in a write-class table. Each table is a small associative array keyed by line address, and a new entry goes into its lowest free slot.

On the cycle a request arrives, the block decides whether to admit it. If it does, the block hands back a fresh identifier and forwards the request downstream together with an issue delay, which depends on whether the request is an instruction fetch. A completion names the table and the line. If it matches an entry, one cycle later the block reports the identifier, the latency in cycles, and the data: bytes extracted from the line for copy-out kinds, or the line with the request's bytes merged in for modifying kinds.

An age watchdog is armed by the first insertion while it is idle. It re-examines the tables every threshold interval and pulses an error when any entry has waited at least that long.

Top module: `req_tracker`

## Requirements
- R1: A request is refused while the number of outstanding entries in both tables together is at or above MAX_OUT.
- R2: A request is refused when its line address (address bits above the byte offset) already has an entry in either table.
- R3: A request is refused when its byte offset plus its length exceeds LINE_BYTES, when its kind code is 7, or when the table for its class has no free slot.
- R4: `req_accept` is high in the same cycle for an admitted request. `req_id` then carries the next identifier of a sequence that starts at 0 after reset and wraps from 2^ID_W-2 back to 0. A refused or absent request gives `req_id` all ones.
- R5: Kind codes 2 to 6 (store, atomic read, atomic write, locked read, locked write) belong to the write-class table, and codes 0 (load) and 1 (fetch) to the read-class table. A completion looks only in the table chosen by `cpl_wr` (1 = write class); a completion with no matching entry produces no report.
- R6: `iss_valid` equals `req_accept`. For an admitted request, `iss_line` and `iss_kind` echo the request, and `iss_delay` is IC_LAT for kind 1 and DC_LAT for every other kind.
- R7: One cycle after a matching completion, `done_valid` pulses with the entry's identifier and `done_lat` set to the number of cycles from the admitting cycle to the completion cycle. The entry is freed.
- R8: For kinds 0, 1 and 3, `done_rdata` holds line bytes offset to offset+len-1 in its low bytes with zeros above, and `done_line` equals `cpl_data`. For the other kinds, `done_rdata` is zero and `done_line` is `cpl_data` with bytes offset to offset+len-1 replaced by the low len bytes of the request's `req_wdata`.
- R9: An insertion while the watchdog is idle arms it to fire THRESH cycles later. In the cycle after firing, `hang` pulses if any entry present during the firing cycle was admitted THRESH or more cycles earlier.
- R10: On firing, the watchdog re-arms for another THRESH cycles if entries remain after that cycle, and otherwise goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Request kind code |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | OFF_W+1 | Access length in bytes |
| req_wdata | input | 8*LINE_BYTES | Write bytes, least significant byte first |
| req_accept | output | 1 | Request admitted |
| req_id | output | ID_W | Assigned identifier, all ones if refused |
| iss_valid | output | 1 | Forward to controller queue |
| iss_kind | output | 3 | Forwarded kind |
| iss_line | output | ADDR_W-OFF_W | Forwarded line address |
| iss_delay | output | DLY_W | Downstream issue delay |
| cpl_valid | input | 1 | Completion present |
| cpl_wr | input | 1 | Completion targets write-class table |
| cpl_line | input | ADDR_W-OFF_W | Completed line address |
| cpl_data | input | 8*LINE_BYTES | Line contents |
| done_valid | output | 1 | Completion report |
| done_id | output | ID_W | Identifier of completed request |
| done_lat | output | TIME_W | Latency in cycles |
| done_rdata | output | 8*LINE_BYTES | Extracted bytes |
| done_line | output | 8*LINE_BYTES | Line after merge |
| hang | output | 1 | Watchdog found an over-age entry |

## Verification
The bench targets refusal from every cause, and the cases where the causes overlap. A design that looked up only the request's own table would admit a store to a line with an outstanding load. A design that sized admission by table capacity alone would admit a seventh request. A design that forgot the line-size check would admit an access that straddles a line. A completion sent to the wrong table must produce no report; a design that searched both tables would retire the entry early. An atomic read that returns data although it lives in the write-class table would come back with zero data if the extraction were keyed on table class. The watchdog is run into both re-arming and going idle: a design that failed to re-arm would miss the second over-age pulse, and one that never went idle would flag entries that are not there.

// File: rtl/rqt_pkg.sv
package rqt_pkg;
   typedef enum logic [2:0] {
      K_LOAD    = 3'd0,
      K_FETCH   = 3'd1,
      K_STORE   = 3'd2,
      K_ATOM_RD = 3'd3,
      K_ATOM_WR = 3'd4,
      K_LOCK_RD = 3'd5,
      K_LOCK_WR = 3'd6,
      K_BAD     = 3'd7
   } kind_e;

   // Kinds that modify or reserve a line live in the write-class table
   function automatic logic in_wr_table(kind_e k);
      return (k == K_STORE) || (k == K_ATOM_RD) || (k == K_ATOM_WR) ||
             (k == K_LOCK_RD) || (k == K_LOCK_WR);
   endfunction

   // Kinds that copy bytes out of the returned line
   function automatic logic copies_out(kind_e k);
      return (k == K_LOAD) || (k == K_FETCH) || (k == K_ATOM_RD);
   endfunction
endpackage

// File: rtl/rqt_table.sv
module rqt_table #(
   parameter int SLOTS  = 4,
   parameter int KEY_W  = 13,
   parameter int PAY_W  = 80,
   parameter int TIME_W = 16,
   parameter int THRESH = 1000,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KEY_W-1:0]  look_key,
   output logic              look_hit,
   input  logic              ins_en,
   input  logic [PAY_W-1:0]  ins_pay,
   input  logic [TIME_W-1:0] now,
   input  logic              del_en,
   input  logic [KEY_W-1:0]  del_key,
   output logic              del_hit,
   output logic [PAY_W-1:0]  del_pay,
   output logic [TIME_W-1:0] del_time,
   output logic              full,
   output logic [CNT_W-1:0]  count,
   output logic              aged
);
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   logic [SLOTS-1:0]  vld, look_m, del_m, old_m;
   logic [KEY_W-1:0]  key_q [SLOTS];
   logic [PAY_W-1:0]  pay_q [SLOTS];
   logic [TIME_W-1:0] tm_q  [SLOTS];
   logic              free_any;
   logic [IDX_W-1:0]  free_idx;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [TIME_W-1:0] age;
      assign age       = now - tm_q[s];
      assign look_m[s] = vld[s] && (key_q[s] == look_key);
      assign del_m[s]  = vld[s] && (key_q[s] == del_key);
      assign old_m[s]  = vld[s] && (age >= TIME_W'(THRESH));
   end

   assign look_hit = |look_m;
   assign del_hit  = |del_m;
   assign aged     = |old_m;
   assign full     = !free_any;

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (!vld[s]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(s);
         end
      end
   end

   always_comb begin
      del_pay  = '0;
      del_time = '0;
      count    = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (del_m[s]) begin
            del_pay  = del_pay | pay_q[s];
            del_time = del_time | tm_q[s];
         end
         count = count + CNT_W'(vld[s]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         for (int s = 0; s < SLOTS; s++)
            if (del_en && del_m[s]) vld[s] <= 1'b0;
         if (ins_en && free_any) vld[free_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en && free_any) begin
         key_q[free_idx] <= look_key;
         pay_q[free_idx] <= ins_pay;
         tm_q[free_idx]  <= now;
      end
   end

   AST_INS_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> free_any);                                   // R3
   AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_m));                                      // R2
   AST_INS_NOT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !look_hit);                                  // R2
   AST_DEL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (del_en && del_hit && !ins_en) |=> (count == $past(count) - CNT_W'(1))); // R7
endmodule

// File: rtl/rqt_watchdog.sv
module rqt_watchdog #(
   parameter int TIME_W = 16,
   parameter int THRESH = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic              arm,
   input  logic              keep,
   input  logic              aged,
   output logic              hang
);
   logic              pending;
   logic [TIME_W-1:0] due;
   logic              fire;

   assign fire = pending && (now == due);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         due     <= '0;
         hang    <= 1'b0;
      end else begin
         hang <= fire && aged;
         if (fire) begin
            if (keep) due <= now + TIME_W'(THRESH);
            else      pending <= 1'b0;
         end else if (!pending && arm) begin
            pending <= 1'b1;
            due     <= now + TIME_W'(THRESH);
         end
      end
   end

   AST_HANG_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      hang |-> $past(fire));                                  // R9
   AST_ARM_ON_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !pending) |=> pending);                         // R9
   AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !keep) |=> !pending);                          // R10
   AST_REARM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && keep) |=> (pending && !fire));                 // R10
endmodule

// File: rtl/rqt_bytelane.sv
module rqt_bytelane #(
   parameter int LINE_BYTES = 8,
   parameter int OFF_W      = 3,
   parameter int LEN_W      = 4
) (
   input  logic [LINE_BYTES*8-1:0] line,
   input  logic [LINE_BYTES*8-1:0] wdata,
   input  logic [OFF_W-1:0]        off,
   input  logic [LEN_W-1:0]        len,
   input  logic                    copy_out,
   output logic [LINE_BYTES*8-1:0] rdata,
   output logic [LINE_BYTES*8-1:0] merged
);
   always_comb begin
      rdata  = '0;
      merged = line;
      for (int b = 0; b < LINE_BYTES; b++) begin
         if (copy_out && (b < int'(len)) && (b + int'(off) < LINE_BYTES))
            rdata[b*8 +: 8] = line[(b + int'(off))*8 +: 8];
         if (!copy_out && (b >= int'(off)) && (b < int'(off) + int'(len)))
            merged[b*8 +: 8] = wdata[(b - int'(off))*8 +: 8];
      end
   end
endmodule

// File: rtl/req_tracker.sv
module req_tracker #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 8,
   parameter int RD_SLOTS   = 4,
   parameter int WR_SLOTS   = 4,
   parameter int MAX_OUT    = 6,
   parameter int ID_W       = 8,
   parameter int TIME_W     = 16,
   parameter int THRESH     = 1000,
   parameter int DLY_W      = 4,
   parameter int IC_LAT     = 2,
   parameter int DC_LAT     = 3,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int LEN_W  = OFF_W + 1,
   localparam int LINE_W = ADDR_W - OFF_W,
   localparam int DATA_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_accept,
   output logic [ID_W-1:0]   req_id,
   output logic              iss_valid,
   output logic [2:0]        iss_kind,
   output logic [LINE_W-1:0] iss_line,
   output logic [DLY_W-1:0]  iss_delay,
   input  logic              cpl_valid,
   input  logic              cpl_wr,
   input  logic [LINE_W-1:0] cpl_line,
   input  logic [DATA_W-1:0] cpl_data,
   output logic              done_valid,
   output logic [ID_W-1:0]   done_id,
   output logic [TIME_W-1:0] done_lat,
   output logic [DATA_W-1:0] done_rdata,
   output logic [DATA_W-1:0] done_line,
   output logic              hang
);
   import rqt_pkg::*;

   localparam int CNT_W = $clog2(RD_SLOTS + WR_SLOTS + 1);
   localparam int PAY_W = 3 + OFF_W + LEN_W + DATA_W + ID_W;
   localparam logic [ID_W-1:0] ID_LAST = {{(ID_W-1){1'b1}}, 1'b0};

   initial begin : p_param_chk
      assert (MAX_OUT >= 1 && MAX_OUT <= RD_SLOTS + WR_SLOTS)
         else $error("MAX_OUT must lie between 1 and the total slot count");
      assert ((1 << OFF_W) == LINE_BYTES) else $error("LINE_BYTES must be a power of two");
      assert (THRESH > 0 && THRESH < (1 << (TIME_W - 1))) else $error("THRESH out of range");
      assert (IC_LAT < (1 << DLY_W) && DC_LAT < (1 << DLY_W)) else $error("latency too wide");
   end

   kind_e              kind;
   logic [LINE_W-1:0]  line;
   logic [OFF_W-1:0]   off;
   logic [LEN_W:0]     span;
   logic               fits, wr_cls, present;
   logic [ID_W-1:0]    id_q;
   logic [TIME_W-1:0]  now;
   logic [CNT_W-1:0]   rd_cnt, wr_cnt, occ, occ_nxt;
   logic               rd_look, wr_look, rd_full, wr_full, rd_aged, wr_aged;
   logic               rd_hit, wr_hit, cpl_hit;
   logic [PAY_W-1:0]   rd_pay, wr_pay, sel_pay, ins_pay;
   logic [TIME_W-1:0]  rd_time, wr_time, sel_time;
   logic [DATA_W-1:0]  lane_rdata, lane_line;

   assign kind    = kind_e'(req_kind);
   assign line    = req_addr[ADDR_W-1:OFF_W];
   assign off     = req_addr[OFF_W-1:0];
   assign span    = {2'b00, off} + {1'b0, req_len};
   assign fits    = span <= (LEN_W+1)'(LINE_BYTES);
   assign wr_cls  = in_wr_table(kind);
   assign present = rd_look || wr_look;
   assign occ     = rd_cnt + wr_cnt;

   assign req_accept = req_valid && (kind != K_BAD) && fits && !present &&
                       (occ < CNT_W'(MAX_OUT)) && !(wr_cls ? wr_full : rd_full);
   assign req_id     = req_accept ? id_q : '1;
   assign iss_valid  = req_accept;
   assign iss_kind   = req_kind;
   assign iss_line   = line;
   assign iss_delay  = (kind == K_FETCH) ? DLY_W'(IC_LAT) : DLY_W'(DC_LAT);
   assign ins_pay    = {req_kind, off, req_len, req_wdata, id_q};

   assign cpl_hit  = cpl_valid && (cpl_wr ? wr_hit : rd_hit);
   assign sel_pay  = cpl_wr ? wr_pay : rd_pay;
   assign sel_time = cpl_wr ? wr_time : rd_time;
   assign occ_nxt  = occ + CNT_W'(req_accept) - CNT_W'(cpl_hit);

   rqt_table #(.SLOTS(RD_SLOTS), .KEY_W(LINE_W), .PAY_W(PAY_W), .TIME_W(TIME_W),
               .THRESH(THRESH), .CNT_W(CNT_W)) u_rd_tbl (
      .clk, .rst_n, .look_key(line), .look_hit(rd_look),
      .ins_en(req_accept && !wr_cls), .ins_pay(ins_pay), .now(now),
      .del_en(cpl_valid && !cpl_wr), .del_key(cpl_line), .del_hit(rd_hit),
      .del_pay(rd_pay), .del_time(rd_time), .full(rd_full), .count(rd_cnt),
      .aged(rd_aged));

   rqt_table #(.SLOTS(WR_SLOTS), .KEY_W(LINE_W), .PAY_W(PAY_W), .TIME_W(TIME_W),
               .THRESH(THRESH), .CNT_W(CNT_W)) u_wr_tbl (
      .clk, .rst_n, .look_key(line), .look_hit(wr_look),
      .ins_en(req_accept && wr_cls), .ins_pay(ins_pay), .now(now),
      .del_en(cpl_valid && cpl_wr), .del_key(cpl_line), .del_hit(wr_hit),
      .del_pay(wr_pay), .del_time(wr_time), .full(wr_full), .count(wr_cnt),
      .aged(wr_aged));

   rqt_bytelane #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_lane (
      .line(cpl_data),
      .wdata(sel_pay[ID_W +: DATA_W]),
      .off(sel_pay[ID_W + DATA_W + LEN_W +: OFF_W]),
      .len(sel_pay[ID_W + DATA_W +: LEN_W]),
      .copy_out(copies_out(kind_e'(sel_pay[PAY_W-1 -: 3]))),
      .rdata(lane_rdata), .merged(lane_line));

   rqt_watchdog #(.TIME_W(TIME_W), .THRESH(THRESH)) u_wdog (
      .clk, .rst_n, .now(now), .arm(req_accept), .keep(occ_nxt != '0),
      .aged(rd_aged || wr_aged), .hang(hang));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q       <= '0;
         now        <= '0;
         done_valid <= 1'b0;
         done_id    <= '0;
         done_lat   <= '0;
         done_rdata <= '0;
         done_line  <= '0;
      end else begin
         now        <= now + TIME_W'(1);
         done_valid <= cpl_hit;
         if (req_accept) id_q <= (id_q == ID_LAST) ? '0 : id_q + ID_W'(1);
         if (cpl_hit) begin
            done_id    <= sel_pay[ID_W-1:0];
            done_lat   <= now - sel_time;
            done_rdata <= lane_rdata;
            done_line  <= lane_line;
         end
      end
   end

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(MAX_OUT));                                // R1
   AST_REFUSED_ID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_accept |-> (req_id == '1));                        // R4
   AST_ID_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      req_accept |=> (id_q != $past(id_q)));                  // R4
   AST_DONE_FROM_CPL: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(cpl_valid));                       // R7
   AST_OCC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (occ == $past(occ_nxt)));                      // R5
endmodule

// File: tb/req_tracker_test.sv
`timescale 1ns/1ps
module req_tracker_test;
   localparam int THR = 24;
   localparam int MAXO = 6;
   localparam int ICL = 2;
   localparam int DCL = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_len = '0;
   logic [63:0] req_wdata = '0;
   logic        req_accept;
   logic [7:0]  req_id;
   logic        iss_valid;
   logic [2:0]  iss_kind;
   logic [12:0] iss_line;
   logic [3:0]  iss_delay;
   logic        cpl_valid = 1'b0;
   logic        cpl_wr = 1'b0;
   logic [12:0] cpl_line = '0;
   logic [63:0] cpl_data = '0;
   logic        done_valid;
   logic [7:0]  done_id;
   logic [15:0] done_lat;
   logic [63:0] done_rdata, done_line;
   logic        hang;

   always #2 clk = ~clk;

   req_tracker #(.THRESH(THR), .MAX_OUT(MAXO), .IC_LAT(ICL), .DC_LAT(DCL)) uut (.*);

   int n_chk = 0, n_fail = 0;

   // behavioural model state
   bit          e_v [16];
   bit          e_wr [16];
   logic [12:0] e_line [16];
   int          e_kind [16], e_off [16], e_len [16], e_id [16];
   logic [63:0] e_wd [16];
   logic [15:0] e_t [16];
   logic [15:0] mnow = '0, mdue = '0;
   bit          mpend = 0;
   int          mid = 0;
   bit          x_dv = 0, x_hang = 0;
   int          x_id = 0;
   logic [15:0] x_lat = '0;
   logic [63:0] x_rd = '0, x_ln = '0;
   string       done_tag = "R7";

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      int nrd = 0, nwr = 0, occ, fnd = -1, slot = -1;
      bit dup = 0, fits, wrc, ok, fire, aged = 0, cp;
      string tg;
      logic [15:0] a;
      #1;
      for (int i = 0; i < 16; i++)
         if (e_v[i]) begin
            if (e_wr[i]) nwr++; else nrd++;
            if (e_line[i] == req_addr[15:3]) dup = 1;
         end
      occ  = nrd + nwr;
      wrc  = (req_kind >= 2) && (req_kind <= 6);
      fits = (int'(req_addr[2:0]) + int'(req_len)) <= 8;
      ok   = req_valid && (req_kind != 7) && fits && !dup && (occ < MAXO) &&
             (wrc ? (nwr < 4) : (nrd < 4));
      tg   = (occ >= MAXO) ? "R1" : dup ? "R2" : "R3";
      chk(req_accept == ok, tg, 64'(req_accept), 64'(ok));
      chk(req_id == (ok ? 8'(mid) : 8'hFF), "R4", 64'(req_id), ok ? 64'(mid) : 64'hFF);
      chk(iss_valid == ok, "R6", 64'(iss_valid), 64'(ok));
      if (ok) begin
         chk(iss_delay == ((req_kind == 1) ? 4'(ICL) : 4'(DCL)), "R6", 64'(iss_delay),
             (req_kind == 1) ? 64'(ICL) : 64'(DCL));
         chk(iss_line == req_addr[15:3] && iss_kind == req_kind, "R6",
             64'({iss_kind, iss_line}), 64'({req_kind, req_addr[15:3]}));
      end
      @(posedge clk);
      // model update with the inputs of the cycle just ended
      for (int i = 0; i < 16; i++)
         if (e_v[i]) begin
            a = mnow - e_t[i];
            if (a >= 16'(THR)) aged = 1;
            if (cpl_valid && e_wr[i] == cpl_wr && e_line[i] == cpl_line) fnd = i;
         end
      x_dv = (fnd >= 0);
      done_tag = (cpl_valid && fnd < 0) ? "R5" : "R7";
      if (fnd >= 0) begin
         x_id  = e_id[fnd];
         x_lat = mnow - e_t[fnd];
         cp    = (e_kind[fnd] == 0) || (e_kind[fnd] == 1) || (e_kind[fnd] == 3);
         x_rd  = '0;
         x_ln  = cpl_data;
         for (int b = 0; b < e_len[fnd]; b++)
            if (cp) x_rd[b*8 +: 8] = cpl_data[(e_off[fnd]+b)*8 +: 8];
            else    x_ln[(e_off[fnd]+b)*8 +: 8] = e_wd[fnd][b*8 +: 8];
      end
      fire   = mpend && (mnow == mdue);
      x_hang = fire && aged;
      if (fire) begin
         if (occ + int'(ok) - int'(fnd >= 0) > 0) mdue = mnow + 16'(THR);
         else mpend = 0;
      end else if (!mpend && ok) begin
         mpend = 1;
         mdue  = mnow + 16'(THR);
      end
      if (fnd >= 0) e_v[fnd] = 0;
      if (ok) begin
         for (int i = 15; i >= 0; i--) if (!e_v[i]) slot = i;
         e_v[slot] = 1; e_wr[slot] = wrc; e_line[slot] = req_addr[15:3];
         e_kind[slot] = int'(req_kind); e_off[slot] = int'(req_addr[2:0]);
         e_len[slot] = int'(req_len); e_wd[slot] = req_wdata;
         e_id[slot] = mid; e_t[slot] = mnow;
         mid = (mid == 254) ? 0 : mid + 1;
      end
      mnow = mnow + 16'd1;
      @(negedge clk);
      chk(done_valid == x_dv, done_tag, 64'(done_valid), 64'(x_dv));
      if (x_dv) begin
         chk(done_id == 8'(x_id) && done_lat == x_lat, "R7",
             64'({done_id, done_lat}), 64'({8'(x_id), x_lat}));
         chk(done_rdata == x_rd, "R8", done_rdata, x_rd);
         chk(done_line == x_ln, "R8", done_line, x_ln);
      end
      chk(hang == x_hang, x_hang ? "R9" : "R10", 64'(hang), 64'(x_hang));
   endtask

   task automatic req(int k, logic [15:0] ad, int ln, logic [63:0] wd);
      req_valid = 1; req_kind = 3'(k); req_addr = ad; req_len = 4'(ln); req_wdata = wd;
      step();
      req_valid = 0;
   endtask

   task automatic cpl(bit wr, logic [12:0] ln, logic [63:0] d);
      cpl_valid = 1; cpl_wr = wr; cpl_line = ln; cpl_data = d;
      step();
      cpl_valid = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk(!req_accept && !done_valid && !hang && req_id == 8'hFF, "R4",
          64'({req_accept, done_valid, hang}), 64'd0);
      rst_n = 1;
      // admission, class routing and issue delay
      req(0, 16'h0010, 4, '0);                    // R6 load, line 2
      req(1, 16'h0020, 8, '0);                    // R6 fetch, line 4
      req(2, 16'h0013, 1, 64'hAA);                // R2 store on line with a load
      req(0, 16'h0014, 2, '0);                    // R2 same table
      req(2, 16'h0035, 4, 64'hDDCCBBAA);          // R3 crosses line end
      req(2, 16'h0035, 3, 64'hCCBBAA);            // store line 6
      req(7, 16'h0040, 1, '0);                    // R3 bad kind
      idle(2);
      cpl(0, 13'd2, 64'h8877665544332211);        // R8 extract at offset 0
      cpl(1, 13'd4, 64'h1);                       // R5 wrong table, no report
      cpl(1, 13'd6, 64'h0807060504030201);        // R8 merge
      cpl(0, 13'd4, 64'hF0E0D0C0B0A09080);        // R7 fetch
      idle(3);
      // capacity limits
      req(2, 16'h0050, 2, 64'h1111);              // store line 10
      req(3, 16'h005A, 4, '0);                    // atomic read line 11
      req(4, 16'h0060, 1, 64'h22);                // atomic write line 12
      req(5, 16'h006F, 1, '0);                    // locked read line 13
      req(6, 16'h0070, 1, 64'h33);                // R3 write table full
      req(0, 16'h00A1, 7, '0);                    // load line 20
      req(1, 16'h00A8, 1, '0);                    // fetch line 21
      req(0, 16'h00B0, 1, '0);                    // R1 at limit
      idle(30);                                   // R9 over-age entries
      cpl(1, 13'd11, 64'h0F0E0D0C0B0A0908);       // R8 atomic read returns data
      cpl(1, 13'd10, 64'h0);
      cpl(1, 13'd12, 64'h0);
      idle(25);                                   // R10 re-armed, fires again
      cpl(1, 13'd13, 64'hFFFF);
      cpl(0, 13'd20, 64'h0123456789ABCDEF);
      cpl(0, 13'd21, 64'h55);
      idle(60);                                   // R10 idle, no further pulse
      req(0, 16'h00B0, 1, '0);                    // R1 room again
      cpl(0, 13'd22, 64'h77);
      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule